// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control and address pins of a four-bank synchronous DRAM. On every rising clock edge where the clock enable is high, it decodes the command on the chip select, row strobe, column strobe and write enable pins. It tracks three commands in full: mode register set, activate and precharge. For each bank it keeps a small state machine with three states. **IDLE** moves to **OPEN** on an accepted activate. **OPEN** moves to **PRECH** on a precharge. **PRECH** moves back to **IDLE** once a per-bank counter has covered the precharge period. A second state machine tracks the mode register. **UNSET** is the state after reset. **RECOVER** is the lockout window after a mode register set. **READY** is the normal operating state. The transitions are UNSET→RECOVER on a legal mode set, RECOVER→READY when the window ends, and READY→RECOVER on another legal mode set; when the window length is one, a legal mode set goes straight to READY.

Any command that breaks the bank-state or timing rules is rejected and sets a sticky violation flag. The flags stay set until a synchronous clear. A controller or a verification environment uses the outputs to see the decoded command, the state and open row of every bank, the current mode word, and which rule was broken.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, every bank reads IDLE (code 0), all five flags read 0, `mode_ok_o` reads 0 and `cmd_o` reads deselect (code 0).
- R2: `cmd_o` shows, one edge later, the command sampled at an edge. The codes are:
  - deselect 0, for `cs_n` high or `cke` low;
  - NOP 1, for ras/cas/we = 111;
  - mode set 2, for 000;
  - activate 3, for 011;
  - precharge 4, for 010;
  - any other encoding 5.
- R3: An activate or precharge while `mode_ok_o` is 0 sets flag bit 4 and changes no bank.
- R4: A mode set when every bank is IDLE and no lockout is running loads `addr` (A13..A0) into `mode_word_o` and sets `mode_ok_o`, which then stays set until reset.
- R5: A mode set while any bank is not IDLE sets flag bit 0 and leaves `mode_word_o` unchanged.
- R6: On the TRSC-1 edges that follow an accepted mode set, any command with code 2 or above sets flag bit 1 and has no effect.
- R7: An activate to an IDLE bank, where the bank is `addr[13:12]`, moves that bank to OPEN (code 1) and stores `addr[11:0]` as its open row.
- R8: An activate to an OPEN bank sets flag bit 3 and leaves that bank's row unchanged.
- R9: A precharge with `addr[10]` low moves only the selected bank from OPEN to PRECH (code 2). With `addr[10]` high, it moves every OPEN bank to PRECH. A precharge does not change an IDLE or PRECH bank.
- R10: A bank precharged at edge T reads IDLE from edge T+TRP. An activate to that bank at edges T+1 through T+TRP-1 sets flag bit 2 and is rejected.
- R11: Flags are sticky. An edge with `clear_flags` high clears them, but a violation detected at that same edge is still recorded.
- R12: With `cke` low, no command takes effect, but precharge and lockout timers keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_flags | input | 1 | Synchronous clear of the sticky flags |
| cke | input | 1 | Clock enable; commands sampled only when high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 14 | A13..A0: bank select, row, all-bank bit, mode value |
| cmd_o | output | 3 | Registered decoded command code |
| bank_state_o | output | 8 | Two bits per bank, bank 0 in the lowest bits |
| open_row_o | output | 48 | Twelve-bit row per bank, bank 0 in the lowest bits |
| mode_ok_o | output | 1 | A legal mode set has been accepted |
| mode_word_o | output | 14 | Last accepted mode value |
| flags_o | output | 5 | Sticky flags, bit by bit: 0 mode set while busy, 1 lockout, 2 activate while precharging, 3 activate while open, 4 uninitialised |

## Verification
The hardest state to reach is an activate that lands on exactly the last precharge cycle, or exactly one cycle after it, while other banks are open and the mode lockout runs at the same time. Random traffic seldom lines these up. Directed sequences therefore place activates at each offset from one to TRP after a single-bank precharge and after an all-bank precharge. They also issue commands on the edge inside the lockout window and on the edge after it. Long random runs with weighted command choice, clock-enable drops and occasional flag clears then cover the mixed cases against a reference model in the bench.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_MRS   = 3'd2,
        CMD_ACT   = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_OTHER = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_PRECH = 2'd2
    } bank_e;

    typedef enum logic [1:0] {
        MS_UNSET   = 2'd0,
        MS_RECOVER = 2'd1,
        MS_READY   = 2'd2
    } mode_e;

    localparam int FLAG_MRS_BUSY  = 0;
    localparam int FLAG_LOCKOUT   = 1;
    localparam int FLAG_ACT_PRECH = 2;
    localparam int FLAG_ACT_OPEN  = 3;
    localparam int FLAG_UNINIT    = 4;
    localparam int NFLAGS         = 5;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_DESEL;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b000:  cmd = CMD_MRS;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_mode_ctl.sv
module sdcmd_mode_ctl
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int TRSC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              all_idle,
    output logic              locked,
    output logic              mode_ok,
    output logic [ADDR_W-1:0] mode_word,
    output logic              err_busy,
    output logic              err_lock
);
    localparam int LCW = (TRSC > 1) ? $clog2(TRSC) : 1;
    localparam logic [LCW-1:0] LOCK_LOAD = LCW'(TRSC - 1);

    mode_e          st_q, st_d;
    logic [LCW-1:0] cnt_q, cnt_d;
    logic           take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= MS_UNSET;
            cnt_q     <= '0;
            mode_word <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (take) mode_word <= addr;
        end
    end

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        take     = 1'b0;
        err_busy = 1'b0;
        err_lock = 1'b0;
        unique case (st_q)
            MS_UNSET, MS_READY: begin
                if (cmd == CMD_MRS) begin
                    if (all_idle) begin
                        take  = 1'b1;
                        cnt_d = LOCK_LOAD;
                        st_d  = (TRSC > 1) ? MS_RECOVER : MS_READY;
                    end else begin
                        err_busy = 1'b1;
                    end
                end
            end
            MS_RECOVER: begin
                err_lock = (cmd != CMD_DESEL) && (cmd != CMD_NOP);
                if (cnt_q <= LCW'(1)) begin
                    st_d  = MS_READY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - LCW'(1);
                end
            end
            default: st_d = MS_UNSET;
        endcase
    end

    assign locked  = (st_q == MS_RECOVER);
    assign mode_ok = (st_q != MS_UNSET);

    a_r6_recover_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_RECOVER) |-> (cnt_q != '0 && cnt_q <= LOCK_LOAD));
    a_r4_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MS_UNSET) |=> (st_q != MS_UNSET));
    a_r5_word_held_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |=> $stable(mode_word));
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int TRP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit,
    input  logic             pre_hit,
    input  logic [ROW_W-1:0] row_in,
    output bank_e            state_o,
    output logic [ROW_W-1:0] row_o,
    output logic             err_open,
    output logic             err_prech
);
    localparam int PCW = $clog2(TRP);
    localparam logic [PCW-1:0] PRE_LOAD = PCW'(TRP - 1);

    bank_e          st_q, st_d;
    logic [PCW-1:0] cnt_q, cnt_d;
    logic           load_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_o <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (load_row) row_o <= row_in;
        end
    end

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        load_row  = 1'b0;
        err_open  = 1'b0;
        err_prech = 1'b0;
        unique case (st_q)
            BK_IDLE: begin
                if (act_hit) begin
                    st_d     = BK_OPEN;
                    load_row = 1'b1;
                end
            end
            BK_OPEN: begin
                if (act_hit) begin
                    err_open = 1'b1;
                end else if (pre_hit) begin
                    st_d  = BK_PRECH;
                    cnt_d = PRE_LOAD;
                end
            end
            BK_PRECH: begin
                err_prech = act_hit;
                if (cnt_q <= PCW'(1)) begin
                    st_d  = BK_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - PCW'(1);
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    assign state_o = st_q;

    a_r8_open_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_OPEN && $past(st_q) == BK_OPEN) |-> $stable(row_o));
    a_r10_no_reopen_from_prech: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_PRECH) |=> (st_q != BK_OPEN));
    a_r10_prech_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_PRECH) |-> (cnt_q != '0 && cnt_q <= PRE_LOAD));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcmd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10,
    parameter int TRP    = 3,
    parameter int TRSC   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_flags,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [ROW_W+BANK_W-1:0]       addr,
    output logic [2:0]                    cmd_o,
    output logic [2*(1<<BANK_W)-1:0]      bank_state_o,
    output logic [ROW_W*(1<<BANK_W)-1:0]  open_row_o,
    output logic                          mode_ok_o,
    output logic [ROW_W+BANK_W-1:0]       mode_word_o,
    output logic [NFLAGS-1:0]             flags_o
);
    localparam int ADDR_W = ROW_W + BANK_W;
    localparam int NBANK  = 1 << BANK_W;

    cmd_e              cmd;
    logic              locked, mode_ok, err_busy, err_lock;
    logic              act_go, pre_go, err_uninit;
    logic [BANK_W-1:0] bsel;
    logic [NBANK-1:0]  act_hit, pre_hit, idle_v, err_open_v, err_prech_v;
    logic [NFLAGS-1:0] new_flags;
    bank_e             bst [NBANK];

    sdcmd_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    sdcmd_mode_ctl #(.ADDR_W(ADDR_W), .TRSC(TRSC)) u_mode (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .all_idle(&idle_v),
        .locked(locked), .mode_ok(mode_ok), .mode_word(mode_word_o),
        .err_busy(err_busy), .err_lock(err_lock)
    );

    assign bsel       = addr[ADDR_W-1:ROW_W];
    assign act_go     = (cmd == CMD_ACT) && !locked && mode_ok;
    assign pre_go     = (cmd == CMD_PRE) && !locked && mode_ok;
    assign err_uninit = (cmd == CMD_ACT || cmd == CMD_PRE) && !locked && !mode_ok;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign act_hit[b] = act_go && (bsel == BANK_W'(b));
        assign pre_hit[b] = pre_go && (addr[AP_BIT] || bsel == BANK_W'(b));

        sdcmd_bank #(.ROW_W(ROW_W), .TRP(TRP)) u_bank (
            .clk(clk), .rst_n(rst_n), .act_hit(act_hit[b]), .pre_hit(pre_hit[b]),
            .row_in(addr[ROW_W-1:0]), .state_o(bst[b]),
            .row_o(open_row_o[b*ROW_W +: ROW_W]),
            .err_open(err_open_v[b]), .err_prech(err_prech_v[b])
        );

        assign idle_v[b]            = (bst[b] == BK_IDLE);
        assign bank_state_o[2*b +: 2] = bst[b];
    end

    always_comb begin
        new_flags                 = '0;
        new_flags[FLAG_MRS_BUSY]  = err_busy;
        new_flags[FLAG_LOCKOUT]   = err_lock;
        new_flags[FLAG_ACT_PRECH] = |err_prech_v;
        new_flags[FLAG_ACT_OPEN]  = |err_open_v;
        new_flags[FLAG_UNINIT]    = err_uninit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
            cmd_o   <= CMD_DESEL;
        end else begin
            flags_o <= (clear_flags ? '0 : flags_o) | new_flags;
            cmd_o   <= cmd;
        end
    end

    assign mode_ok_o = mode_ok;

    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_flags |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
    a_r3_idle_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |-> (&idle_v));
    a_r9_one_bank_per_act: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_hit));
endmodule

// File: tb/sdram_cmd_monitor_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb_top;
    localparam int TRP  = 3;
    localparam int TRSC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_flags = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [13:0] addr = '0;
    logic [2:0]  cmd_o;
    logic [7:0]  bank_state_o;
    logic [47:0] open_row_o;
    logic        mode_ok_o;
    logic [13:0] mode_word_o;
    logic [4:0]  flags_o;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(.TRP(TRP), .TRSC(TRSC)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_flags(clear_flags), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .cmd_o(cmd_o), .bank_state_o(bank_state_o), .open_row_o(open_row_o),
        .mode_ok_o(mode_ok_o), .mode_word_o(mode_word_o), .flags_o(flags_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model
    int          m_st [4];
    int          m_cnt [4];
    logic [11:0] m_row [4];
    int          m_lock;
    bit          m_mok;
    logic [13:0] m_word;
    logic [4:0]  m_flags;
    logic [2:0]  m_cmd;

    task automatic model_reset();
        for (int b = 0; b < 4; b++) begin m_st[b] = 0; m_cnt[b] = 0; m_row[b] = '0; end
        m_lock = 0; m_mok = 0; m_word = '0; m_flags = '0; m_cmd = 3'd0;
    endtask

    function automatic logic [2:0] decode_ref(logic k, logic c, logic r, logic ca, logic w);
        if (!k || c) return 3'd0;
        case ({r, ca, w})
            3'b111: return 3'd1;
            3'b000: return 3'd2;
            3'b011: return 3'd3;
            3'b010: return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    task automatic model_step();
        logic [2:0] d;
        logic [4:0] nf;
        int  ost [4];
        bit  all_idle, locked;
        int  bs;
        d = decode_ref(cke, cs_n, ras_n, cas_n, we_n);
        nf = '0;
        bs = int'(addr[13:12]);
        locked = (m_lock != 0);
        all_idle = 1;
        for (int b = 0; b < 4; b++) begin ost[b] = m_st[b]; if (m_st[b] != 0) all_idle = 0; end
        if (locked) m_lock = m_lock - 1;
        for (int b = 0; b < 4; b++) if (ost[b] == 2) begin
            if (m_cnt[b] == 1) begin m_st[b] = 0; m_cnt[b] = 0; end
            else m_cnt[b] = m_cnt[b] - 1;
        end
        if (locked && d >= 3'd2) nf[1] = 1;
        else if (d == 3'd2) begin
            if (all_idle) begin m_mok = 1; m_word = addr; m_lock = TRSC - 1; end
            else nf[0] = 1;
        end else if (d == 3'd3 || d == 3'd4) begin
            if (!m_mok) nf[4] = 1;
            else if (d == 3'd3) begin
                if (ost[bs] == 0) begin m_st[bs] = 1; m_row[bs] = addr[11:0]; end
                else if (ost[bs] == 1) nf[3] = 1;
                else nf[2] = 1;
            end else begin
                for (int b = 0; b < 4; b++)
                    if ((addr[10] || b == bs) && ost[b] == 1) begin m_st[b] = 2; m_cnt[b] = TRP - 1; end
            end
        end
        m_flags = (clear_flags ? 5'd0 : m_flags) | nf;
        m_cmd = d;
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0]  es;
        logic [47:0] er;
        for (int b = 0; b < 4; b++) begin es[2*b +: 2] = 2'(m_st[b]); er[12*b +: 12] = m_row[b]; end
        chk("R2 R12", "cmd_o", 64'(cmd_o), 64'(m_cmd));
        chk("R7 R9 R10 R12", "bank_state_o", 64'(bank_state_o), 64'(es));
        chk("R7 R8", "open_row_o", 64'(open_row_o), 64'(er));
        chk("R4", "mode_ok_o", 64'(mode_ok_o), 64'(m_mok));
        chk("R4 R5", "mode_word_o", 64'(mode_word_o), 64'(m_word));
        chk("R3 R5 R6 R8 R10 R11", "flags_o", 64'(flags_o), 64'(m_flags));
    endtask

    // one edge: drive at negedge, predict, compare at next negedge
    task automatic step(logic k, logic c, logic r, logic ca, logic w, logic [13:0] a, logic clr);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; addr = a; clear_flags = clr;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic nop();                        step(1, 0, 1, 1, 1, 14'h0, 0); endtask
    task automatic mrs(logic [13:0] v);          step(1, 0, 0, 0, 0, v, 0); endtask
    task automatic act(int b, logic [11:0] row); step(1, 0, 0, 1, 1, {2'(b), row}, 0); endtask
    task automatic pre(int b, logic all);        step(1, 0, 0, 1, 0, {2'(b), 1'b0, all, 10'h0}, 0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sel;
        logic [13:0] ra;
        void'($urandom(32'h5EED_0149));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values while reset held
        chk("R1", "flags in reset", 64'(flags_o), 64'h0);
        chk("R1", "banks in reset", 64'(bank_state_o), 64'h0);
        chk("R1", "mode_ok in reset", 64'(mode_ok_o), 64'h0);
        chk("R1", "cmd in reset", 64'(cmd_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        // R3: activate and precharge before mode set
        act(1, 12'h055); pre(1, 1); nop();
        // R4 then R6: command on the lockout edge, then one after it
        mrs(14'h0233); act(0, 12'h111); act(0, 12'h123);
        // R8: activate an open bank
        act(0, 12'hFFF);
        // R5: mode set while bank 0 open
        mrs(14'h3FFF);
        // R9: single-bank precharge on idle bank 1, open 2 and 3, precharge all
        act(2, 12'hABC); pre(1, 0); act(3, 12'h001);
        pre(2, 0); act(2, 12'h222); act(2, 12'h222); act(2, 12'h222); // R10 offsets 1,2,3
        pre(0, 1); act(0, 12'h010); nop(); act(3, 12'h020); act(0, 12'h030);
        // R11: clear together with a new violation, then plain clear
        step(1, 0, 0, 1, 1, {2'd0, 12'h0}, 1);
        step(1, 0, 1, 1, 1, 14'h0, 1);
        // R12: cke low hides an activate while the timers run
        pre(0, 1); step(0, 0, 0, 1, 1, {2'd1, 12'h777}, 0); nop(); nop(); nop();
        // R2: deselect and an other encoding
        step(1, 1, 0, 1, 1, 14'h0, 0); step(1, 0, 1, 0, 1, 14'h0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            sel = int'($urandom_range(0, 99));
            ra  = 14'($urandom);
            if (sel < 30)      step(1, 0, 0, 1, 1, ra, 0);
            else if (sel < 52) step(1, 0, 0, 1, 0, ra, 0);
            else if (sel < 58) step(1, 0, 0, 0, 0, ra, 0);
            else if (sel < 72) step(1, 0, 1, 1, 1, ra, 0);
            else if (sel < 78) step(1, 1, 1'($urandom), 1'($urandom), 1'($urandom), ra, 0);
            else if (sel < 84) step(1, 0, 1, 1'($urandom), 1'($urandom), ra, 0);
            else if (sel < 94) step(0, 0, 1'($urandom), 1'($urandom), 1'($urandom), ra, 0);
            else               step(1, 0, 1, 1, 1, ra, 1);
        end
        finish_run();
    end
endmodule